// File: doc/BRIEF.md
# Randomized Line Permutation Table

This block sits between a table-driven routine and the memory that holds its lookup table. Each logical line index of the table is mapped to a physical line slot, so the slot a lookup touches says nothing direct about the index the routine wanted. The translate port is a plain combinational lookup. It answers in the same cycle whenever the unit is idle.

When the surrounding logic reports a miss on a protected logical line, the unit draws a partner line from an internal linear feedback shift register. It then moves the contents of the two lines in the backing store and exchanges the two mapping entries. As a result the mapping changes at every miss but never on a hit, and every logical line still reads back its own data. While an exchange is in flight, both translation and new miss events are held off through their ready outputs.

The exchange is run by a five-state machine:

- **IDLE**: translation is served. A miss is accepted on transition *accept* to FETCH_A.
- **FETCH_A**: reads the slot of the missing line. Transition *next* goes to FETCH_B.
- **FETCH_B**: captures that data and reads the partner's slot. Transition *next* goes to STORE_B.
- **STORE_B**: writes the missing line's data into the partner's slot and captures the partner's data. Transition *next* goes to STORE_A.
- **STORE_A**: writes the partner's data into the missing line's old slot and commits the pointer exchange. Transition *commit* returns to IDLE.

Top module: `line_perm_table`

## Requirements
- R1: After reset the mapping is the identity: translating logical index i gives slot i for every i.
- R2: In IDLE, `xl_ready` is 1 and `xl_slot` is the current slot of `xl_index` in the same cycle.
- R3: A miss is accepted only in a cycle where `miss_ready` is 1. A `miss_valid` pulse during an exchange is ignored: it starts no exchange, does not advance the random source, and leaves the mapping as it would otherwise be.
- R4: The partner index is the low log2(LINES) bits of a 16-bit register. This register is seeded with 16'hACE1 at reset. Each step shifts it left by one and inserts, as the new bit 0, the XOR of bits 15, 13, 12 and 10. It steps once per accepted miss and at no other time, and the partner is taken from its value before the step.
- R5: When an exchange completes for missing line a and partner b, the slots of a and b have traded places and every other entry is unchanged.
- R6: Each exchange lasts exactly four busy cycles after the accepting edge, with store port activity in this order:
  - cycle 1: read (`store_re`=1) at the old slot of a;
  - cycle 2: read at the old slot of b;
  - cycle 3: write (`store_we`=1) at the old slot of b, with the data of a;
  - cycle 4: write at the old slot of a, with the data of b.
  Read data is expected on `store_rdata` one cycle after the read address.
- R7: If the partner equals the missing line, the exchange still runs the same four cycles and leaves both the mapping and the stored data unchanged.
- R8: During the four busy cycles `xl_ready` and `miss_ready` are 0.
- R9: The mapping is a bijection at every clock edge.
- R10: Translations alone (hits) never change the mapping.
- R11: After any sequence of exchanges, the store word at the current slot of logical line i holds the data originally placed for line i.
- R12: In the cycle where a miss is accepted, a translation of any index returns the slot from before that exchange.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xl_index | input | log2(LINES) | Logical line to translate |
| xl_slot | output | log2(LINES) | Physical slot of `xl_index` |
| xl_ready | output | 1 | Translation valid (unit idle) |
| miss_valid | input | 1 | Miss reported on a protected line |
| miss_index | input | log2(LINES) | Logical line that missed |
| miss_ready | output | 1 | Miss can be accepted this cycle |
| store_re | output | 1 | Backing store read enable |
| store_we | output | 1 | Backing store write enable |
| store_addr | output | log2(LINES) | Backing store slot address |
| store_wdata | output | DATA_W | Backing store write data |
| store_rdata | input | DATA_W | Backing store read data, one cycle after read |

## Verification
A translation and an accepted miss can occur in the same cycle. The unit must answer the translation from the mapping as it stood before that exchange. The bench provokes this on every miss by driving `xl_index` to the missing line in the accepting cycle, and compares `xl_slot` with the model's pre-exchange slot. It also pulses a second miss in the middle of some exchanges and judges it ignored: the model's random register and mapping are left untouched, and the following slot sweeps and store contents must still match the model.

// File: rtl/line_perm_pkg.sv
package line_perm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_A,
        ST_FETCH_B,
        ST_STORE_B,
        ST_STORE_A
    } swap_state_t;

endpackage

// File: rtl/line_perm_lfsr.sv
module line_perm_lfsr #(
    parameter int          LFSR_W = 16,
    parameter int          OUT_W  = 3,
    parameter logic [LFSR_W-1:0] TAPS = 16'hB400,
    parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [OUT_W-1:0] rnd_bits
);

    logic [LFSR_W-1:0] state_q;
    logic              feedback;

    assign feedback = ^(state_q & TAPS);
    assign rnd_bits = state_q[OUT_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEED;
        end else if (step) begin
            state_q <= {state_q[LFSR_W-2:0], feedback};
        end
    end

    // R4
    lfsr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(state_q));

    // R4
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);

endmodule

// File: rtl/line_perm_map.sv
module line_perm_map #(
    parameter int LINES = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] xl_index,
    output logic [IDX_W-1:0] xl_slot,
    input  logic [IDX_W-1:0] rd_a_idx,
    output logic [IDX_W-1:0] rd_a_slot,
    input  logic [IDX_W-1:0] rd_b_idx,
    output logic [IDX_W-1:0] rd_b_slot,
    input  logic             swap_en,
    input  logic [IDX_W-1:0] swap_a,
    input  logic [IDX_W-1:0] swap_b
);

    logic [IDX_W-1:0]       map_q [LINES];
    logic [LINES*IDX_W-1:0] map_flat;
    logic [LINES-1:0]       occupied;

    for (genvar g = 0; g < LINES; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                map_q[g] <= IDX_W'(g);
            end else if (swap_en && swap_a == IDX_W'(g)) begin
                map_q[g] <= map_q[swap_b];
            end else if (swap_en && swap_b == IDX_W'(g)) begin
                map_q[g] <= map_q[swap_a];
            end
        end
        assign map_flat[g*IDX_W +: IDX_W] = map_q[g];
    end

    assign xl_slot   = map_q[xl_index];
    assign rd_a_slot = map_q[rd_a_idx];
    assign rd_b_slot = map_q[rd_b_idx];

    always_comb begin
        occupied = '0;
        for (int i = 0; i < LINES; i++) begin
            occupied[map_q[i]] = 1'b1;
        end
    end

    // R9
    bijection_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occupied == {LINES{1'b1}});

    // R10
    map_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !swap_en |=> $stable(map_flat));

endmodule

// File: rtl/line_perm_swap.sv
module line_perm_swap
    import line_perm_pkg::*;
#(
    parameter int IDX_W  = 3,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    input  logic [IDX_W-1:0]  miss_index,
    input  logic [IDX_W-1:0]  rnd_bits,
    input  logic [IDX_W-1:0]  slot_a,
    input  logic [IDX_W-1:0]  slot_b,
    input  logic [DATA_W-1:0] store_rdata,
    output logic [IDX_W-1:0]  idx_a,
    output logic [IDX_W-1:0]  idx_b,
    output logic              accept,
    output logic              commit,
    output logic              idle,
    output logic              store_re,
    output logic              store_we,
    output logic [IDX_W-1:0]  store_addr,
    output logic [DATA_W-1:0] store_wdata
);

    swap_state_t       state_q, state_d;
    logic [IDX_W-1:0]  idx_a_q, idx_b_q;
    logic [DATA_W-1:0] hold_a_q, hold_b_q;

    assign idx_a = idx_a_q;
    assign idx_b = idx_b_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (miss_valid) state_d = ST_FETCH_A;
            ST_FETCH_A: state_d = ST_FETCH_B;
            ST_FETCH_B: state_d = ST_STORE_B;
            ST_STORE_B: state_d = ST_STORE_A;
            ST_STORE_A: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_a_q  <= '0;
            idx_b_q  <= '0;
            hold_a_q <= '0;
            hold_b_q <= '0;
        end else begin
            if (accept) begin
                idx_a_q <= miss_index;
                idx_b_q <= rnd_bits;
            end
            if (state_q == ST_FETCH_B) hold_a_q <= store_rdata;
            if (state_q == ST_STORE_B) hold_b_q <= store_rdata;
        end
    end

    always_comb begin
        idle        = 1'b0;
        accept      = 1'b0;
        commit      = 1'b0;
        store_re    = 1'b0;
        store_we    = 1'b0;
        store_addr  = '0;
        store_wdata = '0;
        unique case (state_q)
            ST_IDLE: begin
                idle   = 1'b1;
                accept = miss_valid;
            end
            ST_FETCH_A: begin
                store_re   = 1'b1;
                store_addr = slot_a;
            end
            ST_FETCH_B: begin
                store_re   = 1'b1;
                store_addr = slot_b;
            end
            ST_STORE_B: begin
                store_we    = 1'b1;
                store_addr  = slot_b;
                store_wdata = hold_a_q;
            end
            ST_STORE_A: begin
                store_we    = 1'b1;
                store_addr  = slot_a;
                store_wdata = hold_b_q;
                commit      = 1'b1;
            end
            default: ;
        endcase
    end

    // R6
    order_fa_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_FETCH_A |=> state_q == ST_FETCH_B);

    // R6
    order_fb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_FETCH_B |=> state_q == ST_STORE_B);

    // R6
    order_sb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_STORE_B |=> state_q == ST_STORE_A);

    // R6
    order_sa_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_STORE_A |=> state_q == ST_IDLE);

    // R3
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != ST_IDLE |=> ($stable(idx_a_q) && $stable(idx_b_q)));

endmodule

// File: rtl/line_perm_table.sv
module line_perm_table #(
    parameter int LINES     = 8,
    parameter int DATA_W    = 32,
    parameter int LFSR_W    = 16,
    parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
    parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
    localparam int IDX_W    = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  xl_index,
    output logic [IDX_W-1:0]  xl_slot,
    output logic              xl_ready,
    input  logic              miss_valid,
    input  logic [IDX_W-1:0]  miss_index,
    output logic              miss_ready,
    output logic              store_re,
    output logic              store_we,
    output logic [IDX_W-1:0]  store_addr,
    output logic [DATA_W-1:0] store_wdata,
    input  logic [DATA_W-1:0] store_rdata
);

    logic [IDX_W-1:0] rnd_bits;
    logic [IDX_W-1:0] idx_a, idx_b, slot_a, slot_b;
    logic             accept, commit, idle;

    line_perm_lfsr #(
        .LFSR_W (LFSR_W),
        .OUT_W  (IDX_W),
        .TAPS   (LFSR_TAPS),
        .SEED   (LFSR_SEED)
    ) u_lfsr (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (accept),
        .rnd_bits (rnd_bits)
    );

    line_perm_map #(
        .LINES (LINES),
        .IDX_W (IDX_W)
    ) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .xl_index  (xl_index),
        .xl_slot   (xl_slot),
        .rd_a_idx  (idx_a),
        .rd_a_slot (slot_a),
        .rd_b_idx  (idx_b),
        .rd_b_slot (slot_b),
        .swap_en   (commit),
        .swap_a    (idx_a),
        .swap_b    (idx_b)
    );

    line_perm_swap #(
        .IDX_W  (IDX_W),
        .DATA_W (DATA_W)
    ) u_swap (
        .clk         (clk),
        .rst_n       (rst_n),
        .miss_valid  (miss_valid),
        .miss_index  (miss_index),
        .rnd_bits    (rnd_bits),
        .slot_a      (slot_a),
        .slot_b      (slot_b),
        .store_rdata (store_rdata),
        .idx_a       (idx_a),
        .idx_b       (idx_b),
        .accept      (accept),
        .commit      (commit),
        .idle        (idle),
        .store_re    (store_re),
        .store_we    (store_we),
        .store_addr  (store_addr),
        .store_wdata (store_wdata)
    );

    assign xl_ready   = idle;
    assign miss_ready = idle;

    // R8
    stall_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && miss_ready) |=> (!xl_ready && !miss_ready));

    // R6
    store_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(store_re && store_we) && !((store_re || store_we) && xl_ready));

endmodule

// File: tb/line_perm_table_tb.sv
`timescale 1ns/1ps
module line_perm_table_tb;

    localparam int LINES  = 8;
    localparam int DATA_W = 16;
    localparam int IDX_W  = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [IDX_W-1:0]  xl_index = '0;
    logic [IDX_W-1:0]  xl_slot;
    logic              xl_ready;
    logic              miss_valid = 1'b0;
    logic [IDX_W-1:0]  miss_index = '0;
    logic              miss_ready;
    logic              store_re, store_we;
    logic [IDX_W-1:0]  store_addr;
    logic [DATA_W-1:0] store_wdata;
    logic [DATA_W-1:0] store_rdata = '0;

    logic [DATA_W-1:0] mem [LINES];
    logic [IDX_W-1:0]  map_m [LINES];
    logic [15:0]       lfsr_m;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    line_perm_table #(.LINES(LINES), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .xl_index(xl_index), .xl_slot(xl_slot), .xl_ready(xl_ready),
        .miss_valid(miss_valid), .miss_index(miss_index), .miss_ready(miss_ready),
        .store_re(store_re), .store_we(store_we), .store_addr(store_addr),
        .store_wdata(store_wdata), .store_rdata(store_rdata)
    );

    always @(posedge clk) begin
        if (store_we) mem[store_addr] <= store_wdata;
        if (store_re) store_rdata <= mem[store_addr];
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic sweep();
        for (int i = 0; i < LINES; i++) begin
            xl_index = IDX_W'(i);
            #0.2;
            chk(xl_slot == map_m[i], "R5/R10 slot", int'(xl_slot), int'(map_m[i]));
            chk(mem[map_m[i]] == DATA_W'(16'hA000 + i), "R11 data",
                int'(mem[map_m[i]]), 16'hA000 + i);
        end
    endtask

    task automatic do_miss(input logic [IDX_W-1:0] idx, input bit inject);
        logic [IDX_W-1:0] p, sa, sb, t;
        int busy;
        @(negedge clk);
        miss_valid = 1'b1;
        miss_index = idx;
        xl_index   = idx;
        #0.2;
        p  = lfsr_m[IDX_W-1:0];
        sa = map_m[idx];
        sb = map_m[p];
        chk(miss_ready == 1'b1, "R3 ready", int'(miss_ready), 1);
        chk(xl_ready == 1'b1 && xl_slot == sa, "R12 same-cycle slot", int'(xl_slot), int'(sa));
        @(negedge clk);
        miss_valid = 1'b0;
        busy = 0;
        for (int k = 1; k <= 4; k++) begin
            #0.2;
            if (!miss_ready) busy++;
            chk(!xl_ready, "R8 stall", int'(xl_ready), 0);
            case (k)
                1: chk(store_re && !store_we && store_addr == sa, "R6 read a", int'(store_addr), int'(sa));
                2: chk(store_re && !store_we && store_addr == sb, "R6 read b", int'(store_addr), int'(sb));
                3: chk(store_we && store_addr == sb && store_wdata == DATA_W'(16'hA000 + idx),
                       "R6 write b", int'(store_wdata), 16'hA000 + int'(idx));
                default: chk(store_we && store_addr == sa && store_wdata == DATA_W'(16'hA000 + p),
                       "R6 write a", int'(store_wdata), 16'hA000 + int'(p));
            endcase
            if (inject && k == 2) begin
                miss_valid = 1'b1;
                miss_index = idx ^ 3'd1;
            end
            @(negedge clk);
            miss_valid = 1'b0;
        end
        #0.2;
        chk(busy == 4 && miss_ready, "R6 four busy cycles", busy, 4);
        lfsr_m = {lfsr_m[14:0], ^(lfsr_m & 16'hB400)};
        t = map_m[idx];
        map_m[idx] = map_m[p];
        map_m[p] = t;
        if (p == idx) chk(map_m[idx] == sa, "R7 self swap", int'(map_m[idx]), int'(sa));
        sweep();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < LINES; i++) begin
            mem[i]   = DATA_W'(16'hA000 + i);
            map_m[i] = IDX_W'(i);
        end
        lfsr_m = 16'hACE1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < LINES; i++) begin
            xl_index = IDX_W'(i);
            #0.2;
            chk(xl_slot == IDX_W'(i), "R1 identity", int'(xl_slot), i);
        end
        chk(xl_ready && miss_ready, "R2 idle ready", int'(xl_ready), 1);
        for (int n = 0; n < 32; n++) begin
            if (n % 4 == 3) do_miss(lfsr_m[IDX_W-1:0], 1'b0);
            else            do_miss(IDX_W'(n * 5), n % 3 == 1);
        end
        repeat (12) @(negedge clk);
        sweep();
        sweep();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule